// File: doc/BRIEF.md
# Keyboard Controller Host Interface with Address-Line-20 Gate

This block is the host-facing register side of a legacy keyboard controller. The host sees two byte ports on a simple synchronous strobe bus. The command/status port sits at address 0x64 and the data port at 0x60. A write to either port fills a single input buffer. The controller then takes a fixed, parameterised number of cycles to consume that byte. Until it has, a status flag tells the host to hold off.

The controller keeps an 8-bit output port. A "write output port" command (0xD1) sent to the command port makes the next byte on the data port load that output port. Two of its pins leave the block:
- Bit 1 gates physical address line 20. Until it is set, the outgoing address bit is forced low, so memory addresses wrap at 1 MB.
- Bit 0 drives an active-low CPU reset.

A device-side load strobe fills the output buffer, which the host then reads from the data port.

Top module: `kbc_host_if`

## Requirements
- R1: A host write to address 0x64 is taken as a command byte and a write to 0x60 as a data byte. A read of 0x64 returns the status byte and a read of 0x60 returns the output buffer. Writes to any other address change nothing, and `host_rdata` is 0 when `host_rd` is low or the address is not decoded.
- R2: Status bit 0 (output buffer full) is set on the edge where `dev_load` is high, and the loaded byte is then read at port 0x60. A host read of 0x60 clears bit 0 on that clock edge unless `dev_load` is high in the same cycle.
- R3: Status bit 1 (input buffer full) becomes 1 on the edge that accepts a host write. It returns to 0 exactly CONSUME_CYCLES clock edges later, and that is the edge at which the controller acts on the byte.
- R4: Status bit 3 reads 1 after an accepted write to the command port and 0 after an accepted write to the data port.
- R5: Status bits 2 (system flag), 5, 6 (time-out) and 7 (parity) read 0 from reset onward.
- R6: A host write to either port while status bit 1 is 1 is dropped. It changes neither the buffered byte nor status bit 3, and it sets status bit 4 (write overrun), which stays 1 until reset.
- R7: When command 0xD1 is consumed, the next consumed data byte is loaded into the output port. Any other command consumed in between cancels the pending load. A data byte with no pending 0xD1 leaves the output port unchanged.
- R8: Output port bit 1 drives `a20_gate` and is 0 after reset. `mem_a20_out` equals `cpu_a20_in` AND `a20_gate`.
- R9: Output port bit 0 drives `cpu_reset_n` and is 1 after reset. The pin changes only when a data byte is loaded into the output port under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host port address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (status or output buffer) |
| dev_load | input | 1 | Device side loads a byte into the output buffer |
| dev_byte | input | 8 | Byte loaded by `dev_load` |
| cpu_a20_in | input | 1 | Address bit 20 from the CPU |
| mem_a20_out | output | 1 | Gated address bit 20 to memory |
| a20_gate | output | 1 | Output port bit 1, A20 enable |
| cpu_reset_n | output | 1 | Output port bit 0, active-low CPU reset |

## Verification
The assertions assume that at most one decoded port is written per cycle and that a write strobe lasts exactly one clock. They also assume that CONSUME_CYCLES is at least 1, so that every accepted byte is consumed exactly once.

The bench drives each strobe for a single cycle at the falling edge. It deliberately issues back-to-back writes only to test that a write arriving while the input buffer is full is dropped. Every other write waits until the consume time has run out.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam logic [7:0] PORT_CMD_STAT = 8'h64;
    localparam logic [7:0] PORT_DATA     = 8'h60;
    localparam logic [7:0] CMD_WR_OUTPORT = 8'hD1;

    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_CMD  = 3;
    localparam int ST_OVR  = 4;

    localparam int OP_RESET_N = 0;
    localparam int OP_A20     = 1;
endpackage

// File: rtl/kbc_inbuf.sv
module kbc_inbuf #(
    parameter int CONSUME_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cmd,
    input  logic       wr_data,
    input  logic [7:0] wdata,
    output logic       ibf,
    output logic       last_cmd,
    output logic [7:0] byte_out,
    output logic       consume,
    output logic       overrun
);
    localparam int CW = $clog2(CONSUME_CYCLES + 1);

    typedef struct packed {
        logic          ibf;
        logic          cmd;
        logic [7:0]    data;
        logic [CW-1:0] cnt;
        logic          ovr;
    } inbuf_t;

    inbuf_t st_d, st_q;
    logic   consume_w;

    always_comb begin
        st_d      = st_q;
        consume_w = st_q.ibf && (st_q.cnt == CW'(1));
        if (st_q.ibf) begin
            if (consume_w) begin
                st_d.ibf = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
        if (wr_cmd || wr_data) begin
            if (st_q.ibf) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.ibf  = 1'b1;
                st_d.cmd  = wr_cmd;
                st_d.data = wdata;
                st_d.cnt  = CW'(CONSUME_CYCLES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ibf      = st_q.ibf;
    assign last_cmd = st_q.cmd;
    assign byte_out = st_q.data;
    assign consume  = consume_w;
    assign overrun  = st_q.ovr;

    AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ibf && (wr_cmd || wr_data)) |=> ibf); // R3
    AST_IBF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ibf && !consume) |=> ibf); // R3
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(CONSUME_CYCLES)); // R3
    AST_DROP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ibf && !consume) |=> ($stable(byte_out) && $stable(last_cmd))); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R6
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport #(
    parameter logic [7:0] RESET_VAL = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       consume,
    input  logic       is_cmd,
    input  logic [7:0] byte_in,
    output logic [7:0] port
);
    import kbc_pkg::*;

    typedef struct packed {
        logic       pend;
        logic [7:0] port;
    } oport_t;

    oport_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (consume) begin
            if (is_cmd) begin
                st_d.pend = (byte_in == CMD_WR_OUTPORT);
            end else if (st_q.pend) begin
                st_d.port = byte_in;
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b0, port: RESET_VAL};
        else        st_q <= st_d;
    end

    assign port = st_q.port;

    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !consume |=> $stable(port)); // R9
    AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !is_cmd && st_q.pend) |=> (port == $past(byte_in))); // R7
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if #(
    parameter int         CONSUME_CYCLES = 4,
    parameter logic [7:0] OUTPORT_RESET  = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       dev_load,
    input  logic [7:0] dev_byte,
    input  logic       cpu_a20_in,
    output logic       mem_a20_out,
    output logic       a20_gate,
    output logic       cpu_reset_n
);
    import kbc_pkg::*;

    typedef struct packed {
        logic       obf;
        logic [7:0] obuf;
    } obuf_t;

    obuf_t      ob_d, ob_q;
    logic       sel_cmd, sel_data;
    logic       ibf, last_cmd, consume, overrun;
    logic [7:0] ib_byte, oport, status;

    assign sel_cmd  = (host_addr == PORT_CMD_STAT);
    assign sel_data = (host_addr == PORT_DATA);

    kbc_inbuf #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_inbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd(host_wr && sel_cmd), .wr_data(host_wr && sel_data),
        .wdata(host_wdata),
        .ibf(ibf), .last_cmd(last_cmd), .byte_out(ib_byte),
        .consume(consume), .overrun(overrun)
    );

    kbc_outport #(.RESET_VAL(OUTPORT_RESET)) u_outport (
        .clk(clk), .rst_n(rst_n),
        .consume(consume), .is_cmd(last_cmd), .byte_in(ib_byte),
        .port(oport)
    );

    always_comb begin
        ob_d = ob_q;
        if (host_rd && sel_data) ob_d.obf = 1'b0;
        if (dev_load) begin
            ob_d.obf  = 1'b1;
            ob_d.obuf = dev_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ob_q <= '0;
        else        ob_q <= ob_d;
    end

    always_comb begin
        status          = '0;
        status[ST_OBF]  = ob_q.obf;
        status[ST_IBF]  = ibf;
        status[ST_CMD]  = last_cmd;
        status[ST_OVR]  = overrun;
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (sel_cmd)       host_rdata = status;
            else if (sel_data) host_rdata = ob_q.obuf;
        end
    end

    assign a20_gate    = oport[OP_A20];
    assign cpu_reset_n = oport[OP_RESET_N];
    assign mem_a20_out = cpu_a20_in & a20_gate;

    AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel_data && !dev_load) |=> !ob_q.obf); // R2
    AST_OBF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_load |=> (ob_q.obf && ob_q.obuf == $past(dev_byte))); // R2
    AST_A20_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_gate |-> !mem_a20_out); // R8
endmodule

// File: tb/tb_kbc_host_if.sv
module tb_kbc_host_if;
    localparam int CONSUME = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       dev_load = 1'b0;
    logic [7:0] dev_byte = 8'h00;
    logic       cpu_a20_in = 1'b0;
    logic       mem_a20_out, a20_gate, cpu_reset_n;

    int checks = 0;
    int errors = 0;

    kbc_host_if #(.CONSUME_CYCLES(CONSUME), .OUTPORT_RESET(8'h01)) dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_load(dev_load), .dev_byte(dev_byte), .cpu_a20_in(cpu_a20_in),
        .mem_a20_out(mem_a20_out), .a20_gate(a20_gate), .cpu_reset_n(cpu_reset_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] s);
        host_addr = 8'h64; host_rd = 1'b1;
        #1 s = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic wait_consumed();
        repeat (CONSUME) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        read_status(s);
        check("R5 reset status", s, 8'h00);
        check("R9 reset cpu_reset_n", {7'b0, cpu_reset_n}, 8'h01);
        check("R8 reset a20_gate", {7'b0, a20_gate}, 8'h00);
        cpu_a20_in = 1'b1; #1;
        check("R8 masked a20", {7'b0, mem_a20_out}, 8'h00);
        cpu_a20_in = 1'b0;
    endtask

    task automatic t_ibf_timing();
        logic [7:0] s;
        host_write(8'h64, 8'hAA);
        read_status(s);
        check("R3 ibf set", {7'b0, s[1]}, 8'h01);
        check("R4 cmd flag", {7'b0, s[3]}, 8'h01);
        repeat (CONSUME - 1) @(negedge clk);
        read_status(s);
        check("R3 ibf still set", {7'b0, s[1]}, 8'h01);
        @(negedge clk);
        read_status(s);
        check("R3 ibf cleared", {7'b0, s[1]}, 8'h00);
        host_write(8'h60, 8'h55);
        read_status(s);
        check("R4 data flag", {7'b0, s[3]}, 8'h00);
        wait_consumed();
        check("R7 data w/o cmd a20", {7'b0, a20_gate}, 8'h00);
        check("R7 data w/o cmd rst", {7'b0, cpu_reset_n}, 8'h01);
    endtask

    task automatic t_other_addr();
        logic [7:0] s;
        host_write(8'h61, 8'hD1);
        read_status(s);
        check("R1 other addr ignored", s, 8'h00);
        host_addr = 8'h61; host_rd = 1'b1; #1;
        check("R1 other addr reads 0", host_rdata, 8'h00);
        host_rd = 1'b0;
    endtask

    task automatic t_overrun();
        logic [7:0] s;
        host_write(8'h64, 8'hD1);
        host_write(8'h60, 8'hDF);
        read_status(s);
        check("R6 overrun flag", {7'b0, s[4]}, 8'h01);
        check("R6 dropped keeps cmd flag", {7'b0, s[3]}, 8'h01);
        wait_consumed();
        check("R6 dropped byte no effect", {7'b0, a20_gate}, 8'h00);
        host_write(8'h60, 8'h01);
        wait_consumed();
        read_status(s);
        check("R6 overrun sticky", {7'b0, s[4]}, 8'h01);
        check("R5 fixed zero bits", s & 8'hE4, 8'h00);
    endtask

    task automatic t_a20_enable();
        host_write(8'h64, 8'hD1);
        wait_consumed();
        host_write(8'h60, 8'hDF);
        repeat (CONSUME - 1) @(negedge clk);
        check("R7 not before consume", {7'b0, a20_gate}, 8'h00);
        @(negedge clk);
        check("R7 a20 enabled", {7'b0, a20_gate}, 8'h01);
        cpu_a20_in = 1'b1; #1;
        check("R8 a20 passes 1", {7'b0, mem_a20_out}, 8'h01);
        cpu_a20_in = 1'b0; #1;
        check("R8 a20 passes 0", {7'b0, mem_a20_out}, 8'h00);
        check("R9 reset stays high", {7'b0, cpu_reset_n}, 8'h01);
    endtask

    task automatic t_cancel();
        host_write(8'h64, 8'hD1);
        wait_consumed();
        host_write(8'h64, 8'hAA);
        wait_consumed();
        host_write(8'h60, 8'h00);
        wait_consumed();
        check("R7 cancel keeps a20", {7'b0, a20_gate}, 8'h01);
        check("R7 cancel keeps reset", {7'b0, cpu_reset_n}, 8'h01);
    endtask

    task automatic t_cpu_reset();
        host_write(8'h64, 8'hD1);
        wait_consumed();
        host_write(8'h60, 8'hDE);
        wait_consumed();
        check("R9 reset asserted", {7'b0, cpu_reset_n}, 8'h00);
        host_write(8'h60, 8'hDF);
        repeat (20) @(negedge clk);
        check("R9 reset held", {7'b0, cpu_reset_n}, 8'h00);
        host_write(8'h64, 8'hD1);
        wait_consumed();
        host_write(8'h60, 8'hDF);
        wait_consumed();
        check("R9 reset released", {7'b0, cpu_reset_n}, 8'h01);
    endtask

    task automatic t_obf();
        logic [7:0] s;
        dev_byte = 8'h3C; dev_load = 1'b1;
        @(negedge clk);
        dev_load = 1'b0;
        read_status(s);
        check("R2 obf set", {7'b0, s[0]}, 8'h01);
        host_addr = 8'h60; host_rd = 1'b1; #1;
        check("R2 data read", host_rdata, 8'h3C);
        @(negedge clk);
        host_rd = 1'b0;
        read_status(s);
        check("R2 obf cleared", {7'b0, s[0]}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ibf_timing();
        t_other_addr();
        t_overrun();
        t_a20_enable();
        t_cancel();
        t_cpu_reset();
        t_obf();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule